// File: doc/BRIEF.md
# Pipeline Hazard and Stall Controller

This block decides, every cycle, whether a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) may advance. It watches the register fields and the control flags of the instructions in decode, execute and memory. From them it drives four controls: a PC freeze, a decode-latch freeze, a no-op insert into the decode/execute latch, and a no-op insert into the fetch/decode latch. It also drives a flush for a taken branch and the two operand-select codes of the ALU input multiplexers. The unit is purely combinational, so all of its outputs follow its inputs within the same cycle.

The register file writes in the first half of a cycle and reads in the second. A consumer therefore only waits while its producer is in execute or memory. One parameter enables a single forwarding path, from the execute/memory latch back to the ALU, for the instruction that immediately follows an ALU producer. Another parameter tells the unit that instructions and data share one memory port. In that mode a load or store in memory blocks the fetch of that cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: With forwarding disabled, a used decode source equal to the destination of a producer in execute or in memory gives a data stall: pc_hold=1, id_hold=1, ex_nop=1.
- R2: With forwarding enabled, a match against an execute-stage ALU producer causes no stall. A match against an execute-stage load causes a data stall, and so does a match against any memory-stage producer.
- R3: Operand select codes are 2 bits wide: 2'b00 takes the register file and 2'b01 takes the execute/memory ALU result. Code 2'b10 is never driven. With forwarding enabled, opa_sel is 2'b01 exactly when the memory-stage producer is not a load and its destination equals ex_src_a; opb_sel works the same way against ex_src_b. With forwarding disabled, both codes stay 2'b00.
- R4: A producer whose destination is register 0, or whose write enable is low, never causes a stall or a forward.
- R5: A store never acts as a producer, even with its write enable set.
- R6: A decode source field whose use flag is low is ignored.
- R7: With a shared memory, a load or store in memory with no data stall gives pc_hold=1 and if_nop=1, while id_hold=0 and ex_nop=0. With split memories it has no effect.
- R8: When a data stall and a structural conflict coincide, the data stall form is driven (id_hold=1, if_nop=0).
- R9: flush=1 exactly when the execute instruction is a branch and its outcome is taken. flush forces pc_hold, id_hold, if_nop and ex_nop to 0. A not-taken branch, or a taken flag without a branch, has no effect.
- R10: With no hazard, all hold, insert and flush outputs are 0 and both select codes are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | RW | first source register of decode instruction |
| dec_src_b | input | RW | second source register of decode instruction |
| dec_use_a | input | 1 | first source is read |
| dec_use_b | input | 1 | second source is read |
| ex_dst | input | RW | destination of execute instruction |
| ex_wen | input | 1 | execute instruction writes a register |
| ex_load | input | 1 | execute instruction is a load |
| ex_store | input | 1 | execute instruction is a store |
| ex_src_a | input | RW | first ALU source register of execute instruction |
| ex_src_b | input | RW | second ALU source register of execute instruction |
| ex_branch | input | 1 | execute instruction is a conditional branch |
| ex_taken | input | 1 | branch outcome is taken |
| mem_dst | input | RW | destination of memory-stage instruction |
| mem_wen | input | 1 | memory-stage instruction writes a register |
| mem_load | input | 1 | memory-stage instruction is a load |
| mem_store | input | 1 | memory-stage instruction is a store |
| pc_hold | output | 1 | freeze the PC |
| id_hold | output | 1 | freeze the fetch/decode latch |
| if_nop | output | 1 | load a no-op into the fetch/decode latch |
| ex_nop | output | 1 | load a no-op into the decode/execute latch |
| flush | output | 1 | squash fetch/decode and decode/execute latches |
| opa_sel | output | 2 | first ALU operand select |
| opb_sel | output | 2 | second ALU operand select |

## Verification
The in-module assertions assume that each stage presents one consistent instruction: a load is not also flagged as a store, and ex_taken only matters together with ex_branch. The stimulus keeps to this. Every vector describes one legal snapshot of the three stages, including the mixed cases where a store claims a write enable. Two instances with opposite parameter settings receive each snapshot. This shows that the same hazard pattern produces a stall in one configuration and a forward in the other.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int RW = 5,
  parameter bit FWD_EN = 1'b0,
  parameter bit SHARED_MEM = 1'b1
) (
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic          dec_use_a,
  input  logic          dec_use_b,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic          ex_store,
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic          ex_branch,
  input  logic          ex_taken,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic          mem_store,
  output logic          pc_hold,
  output logic          id_hold,
  output logic          if_nop,
  output logic          ex_nop,
  output logic          flush,
  output logic [1:0]    opa_sel,
  output logic [1:0]    opb_sel
);
  localparam logic [RW-1:0] ZERO = '0;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_ALU = 2'b01;

  logic ex_prod, mem_prod, ex_hit, mem_hit, data_stall, port_busy, mem_alu;

  assign ex_prod  = ex_wen  && !ex_store  && (ex_dst  != ZERO);
  assign mem_prod = mem_wen && !mem_store && (mem_dst != ZERO);
  assign mem_alu  = mem_prod && !mem_load;

  assign ex_hit  = ex_prod  && ((dec_use_a && dec_src_a == ex_dst)  || (dec_use_b && dec_src_b == ex_dst));
  assign mem_hit = mem_prod && ((dec_use_a && dec_src_a == mem_dst) || (dec_use_b && dec_src_b == mem_dst));

  assign data_stall = mem_hit || (ex_hit && (!FWD_EN || ex_load));
  assign port_busy  = SHARED_MEM && (mem_load || mem_store);
  assign flush      = ex_branch && ex_taken;

  assign pc_hold = !flush && (data_stall || port_busy);
  assign id_hold = !flush && data_stall;
  assign ex_nop  = !flush && data_stall;
  assign if_nop  = !flush && port_busy && !data_stall;

  assign opa_sel = (FWD_EN && mem_alu && mem_dst == ex_src_a) ? SEL_ALU : SEL_RF;
  assign opb_sel = (FWD_EN && mem_alu && mem_dst == ex_src_b) ? SEL_ALU : SEL_RF;

  always_comb begin
    p_flush_wins_r9: assert (!(ex_branch && ex_taken) || !(pc_hold || id_hold || if_nop || ex_nop))
      else $error("flush did not override stalls");
    p_zero_dst_r4: assert (!(ex_dst == ZERO && mem_dst == ZERO && !mem_load && !mem_store) || !pc_hold)
      else $error("register 0 caused a stall");
    p_fwd_src_r3: assert (opa_sel != SEL_ALU || (mem_dst == ex_src_a && mem_dst != ZERO && !mem_load))
      else $error("illegal forward on operand a");
    p_no_code2_r3: assert (opa_sel != 2'b10 && opb_sel != 2'b10)
      else $error("reserved select code driven");
    p_stall_form_r8: assert (!(id_hold && if_nop))
      else $error("both fetch-side controls active");
    p_split_mem_r7: assert (SHARED_MEM || !if_nop)
      else $error("structural insert with split memories");
    p_store_idle_r5: assert (!(ex_store && mem_store && !SHARED_MEM) || !pc_hold)
      else $error("store acted as producer");
  end
endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] dsa, dsb, exd, exa, exb, md;
  logic dua, dub, exw, exl, exs, exbr, extk, mw, ml, ms;
  logic ph0, ih0, in0, xn0, fl0, ph1, ih1, in1, xn1, fl1;
  logic [1:0] a0, b0, a1, b1;

  hazard_ctrl #(.RW(5), .FWD_EN(1'b0), .SHARED_MEM(1'b1)) u_dut (
    .dec_src_a(dsa), .dec_src_b(dsb), .dec_use_a(dua), .dec_use_b(dub),
    .ex_dst(exd), .ex_wen(exw), .ex_load(exl), .ex_store(exs),
    .ex_src_a(exa), .ex_src_b(exb), .ex_branch(exbr), .ex_taken(extk),
    .mem_dst(md), .mem_wen(mw), .mem_load(ml), .mem_store(ms),
    .pc_hold(ph0), .id_hold(ih0), .if_nop(in0), .ex_nop(xn0), .flush(fl0),
    .opa_sel(a0), .opb_sel(b0));

  hazard_ctrl #(.RW(5), .FWD_EN(1'b1), .SHARED_MEM(1'b0)) u_dut_fw (
    .dec_src_a(dsa), .dec_src_b(dsb), .dec_use_a(dua), .dec_use_b(dub),
    .ex_dst(exd), .ex_wen(exw), .ex_load(exl), .ex_store(exs),
    .ex_src_a(exa), .ex_src_b(exb), .ex_branch(exbr), .ex_taken(extk),
    .mem_dst(md), .mem_wen(mw), .mem_load(ml), .mem_store(ms),
    .pc_hold(ph1), .id_hold(ih1), .if_nop(in1), .ex_nop(xn1), .flush(fl1),
    .opa_sel(a1), .opb_sel(b1));

  typedef struct {
    logic [8:0] e0;
    logic [8:0] e1;
    string      tag;
  } item_t;
  item_t sb[$];

  localparam logic [8:0] NONE = 9'b00000_00_00;
  localparam logic [8:0] DST  = 9'b11010_00_00;
  localparam logic [8:0] SST  = 9'b10100_00_00;
  localparam logic [8:0] FLS  = 9'b00001_00_00;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  task automatic idle();
    dsa = 0; dsb = 0; dua = 0; dub = 0; exd = 0; exa = 0; exb = 0; md = 0;
    exw = 0; exl = 0; exs = 0; exbr = 0; extk = 0; mw = 0; ml = 0; ms = 0;
  endtask

  task automatic push(input logic [8:0] e0, input logic [8:0] e1, input string tag);
    item_t it;
    it.e0 = e0; it.e1 = e1; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    idle();
  endtask

  always @(posedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks += 2;
      if ({ph0, ih0, in0, xn0, fl0, a0, b0} !== it.e0) begin
        fails++;
        $display("FAIL %s (split-free/no-fwd) actual=%b expected=%b", it.tag,
                 {ph0, ih0, in0, xn0, fl0, a0, b0}, it.e0);
      end
      if ({ph1, ih1, in1, xn1, fl1, a1, b1} !== it.e1) begin
        fails++;
        $display("FAIL %s (fwd/split) actual=%b expected=%b", it.tag,
                 {ph1, ih1, in1, xn1, fl1, a1, b1}, it.e1);
      end
    end
  end

  initial begin
    idle();
    @(negedge clk);
    push(NONE, NONE, "R10 idle");
    dsa = 5; dua = 1; exd = 5; exw = 1;
    push(DST, NONE, "R1 R2 ex alu match");
    dsb = 5; dub = 1; md = 5; mw = 1;
    push(DST, DST, "R1 R2 mem match");
    dsa = 5; dua = 1; exd = 5; exw = 1; exl = 1;
    push(DST, DST, "R2 load use");
    dsa = 0; dua = 1; exd = 0; exw = 1;
    push(NONE, NONE, "R4 reg zero");
    dsa = 5; dua = 1; exd = 5; exw = 0;
    push(NONE, NONE, "R4 no wen");
    dsa = 5; dua = 1; exd = 5; exw = 1; exs = 1;
    push(NONE, NONE, "R5 store ex");
    dsb = 5; dub = 0; exd = 5; exw = 1;
    push(NONE, NONE, "R6 unused src");
    md = 9; mw = 1; ml = 1;
    push(SST, NONE, "R7 mem load port");
    md = 3; ms = 1; dsa = 4; dua = 1; exd = 4; exw = 1;
    push(DST, NONE, "R8 data over struct");
    exbr = 1; extk = 1; dsa = 5; dua = 1; exd = 5; exw = 1; md = 5; mw = 1; ml = 1;
    push(FLS, FLS, "R9 taken flush");
    exbr = 1; extk = 0;
    push(NONE, NONE, "R9 not taken");
    exbr = 0; extk = 1;
    push(NONE, NONE, "R9 taken without branch");
    exa = 7; exb = 8; md = 7; mw = 1;
    push(NONE, 9'b00000_01_00, "R3 fwd a");
    exa = 7; exb = 8; md = 8; mw = 1;
    push(NONE, 9'b00000_00_01, "R3 fwd b");
    exa = 7; exb = 7; md = 7; mw = 1;
    push(NONE, 9'b00000_01_01, "R3 fwd both");
    exa = 7; md = 7; mw = 1; ml = 1;
    push(SST, NONE, "R3 no fwd from load");
    exa = 0; exb = 0; md = 0; mw = 1;
    push(NONE, NONE, "R4 no fwd from reg zero");
    exa = 7; md = 7; mw = 1; ms = 1;
    push(SST, NONE, "R5 no fwd from store");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule